// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a serial audio stream into parallel samples. It oversamples three external lines with its own system clock: a bit clock, a frame clock and a data line. From them it recovers words in five framings: I2S, left-justified, right-justified, an 8-slot TDM frame and a 16-slot TDM frame. The block is always a slave to the external clocks. Each recovered word leaves as a left-aligned 24-bit two's complement value. The word carries a slot index and a flag that says whether it belongs to the second half of the frame (the right channel in two-channel framings).

A single 8-bit configuration word chooses the framing and the clock polarities. It also sets the word length for right-justified data and whether a TDM frame is marked by a half-frame clock or by a one-bit pulse. Bits [2:0] hold the framing: 0 is I2S, 1 is left-justified, 2 is right-justified, 3 is 8-slot TDM, 4 is 16-slot TDM, and 5 to 7 act as I2S. Bit 3 moves sampling to the falling bit-clock edge. Bit 4 inverts the frame clock. Bits [6:5] set the right-justified length: 0 is 24 bits, 1 is 20 bits, 2 and 3 are 16 bits. Bit 7 selects pulse framing in TDM. The configuration may only change while reset is held.

The output side is a stream with a valid strobe and no ready. The serial source cannot be paused, so the sink must accept every strobe in the cycle it appears. Strobes are at least one bit-clock period apart, and the bit-clock period must span at least two system clocks in each phase.

Top module: `audio_serial_rx`

## Requirements
- R1: With the all-zero configuration (I2S), the left word begins at a falling frame-clock edge and its MSB is sampled one bit clock after that edge. The left word is reported as slot 0 with the right flag low, and the right word (frame clock high) as slot 1 with the flag high.
- R2: In left-justified mode a frame begins at a rising frame-clock edge and the MSB is sampled on the bit clock of that edge. Left is frame clock high (slot 0), right is low (slot 1).
- R3: In right-justified mode each half frame is 32 bit clocks, with left while the frame clock is high. Length code 0, 1 and 2 places the MSB 8, 12 or 16 bit clocks after the edge, for 24-, 20- and 16-bit words. The word is output left-aligned with its unused low bits zero.
- R4: When a half frame or slot carries more than 24 bits, the first 24 are kept and the rest are dropped. The word is presented once its 24th bit has been sampled.
- R5: In I2S and left-justified modes, a half frame with fewer than 24 bits is presented at the next frame-clock transition, left-aligned with zero low bits.
- R6: In 8-slot TDM with clock framing, the frame begins at a falling frame-clock edge and the slot-0 MSB comes one bit clock later. Each slot is 32 bit clocks. Slots 0 to 7 are reported in order, with the right flag set for slots 4 to 7.
- R7: In 16-slot TDM, slots 0 to 15 are reported in order, with the right flag set for slots 8 to 15.
- R8: With pulse framing in TDM (bit 7 set), the frame begins at the rising edge of a one-bit-clock pulse and the slot-0 MSB comes one bit clock later.
- R9: Configuration bit 3 moves sampling to the falling bit-clock edge, and bit 4 inverts the frame clock. The recovered words are then identical to those of the uninverted stream.
- R10: Each word is presented by a strobe lasting exactly one system clock. Words arrive in stream order and are never back to back.
- R11: No word is presented for bits received before the first frame start after reset, so the first word out is slot 0.
- R12: During and right after reset the strobe is low, and an idle bit clock produces no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 8 | Framing, polarity, right-justified length and TDM marker select |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | External frame clock or frame pulse |
| sdata | input | 1 | Serial data, MSB first |
| out_valid | output | 1 | One-cycle strobe marking a recovered word |
| out_data | output | 24 | Left-aligned two's complement word |
| out_slot | output | 4 | Slot index (0/1 for left/right in two-channel modes) |
| out_right | output | 1 | Word belongs to the second half of the frame |

## Verification
Two-channel framings are driven with half frames shorter than, equal to and longer than 24 bits. These separate the end-of-word flush at a frame-clock transition from capture that stops at the 24th bit and from truncation of extra bits. The right-justified codes shift the MSB by 8, 12 and 16 bit clocks, so an off-by-one offset or a missing zero fill shows up directly. TDM frames of 8 and 16 slots under clock and pulse framing separate which frame-clock edge starts the frame and where the half-frame flag switches. Inverted polarities and a stretch of random bits before the first frame start show whether sampling moves to the other edge and whether words from before the first frame start leak out.

// File: rtl/audrx_pkg.sv
`timescale 1ns/1ps
package audrx_pkg;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'd0,
    FMT_LJ    = 3'd1,
    FMT_RJ    = 3'd2,
    FMT_TDM8  = 3'd3,
    FMT_TDM16 = 3'd4
  } fmt_e;

  typedef struct packed {
    logic [3:0] slot;
    logic       right;
  } tag_t;

endpackage

// File: rtl/audrx_edge_sync.sv
`timescale 1ns/1ps
module audrx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic lrclk,
  input  logic sdata,
  input  logic bclk_inv,
  output logic stb,
  output logic lr_s,
  output logic dat_s
);

  logic [STAGES-1:0] b_sh, l_sh, d_sh;
  logic b_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_sh   <= '0;
      l_sh   <= '0;
      d_sh   <= '0;
      b_last <= 1'b0;
    end else begin
      b_sh   <= {b_sh[STAGES-2:0], bclk};
      l_sh   <= {l_sh[STAGES-2:0], lrclk};
      d_sh   <= {d_sh[STAGES-2:0], sdata};
      b_last <= b_sh[STAGES-1];
    end
  end

  // Sampling edge: rising edge of the polarity-adjusted bit clock.
  assign stb   = (b_sh[STAGES-1] ^ bclk_inv) & ~(b_last ^ bclk_inv);
  assign lr_s  = l_sh[STAGES-1];
  assign dat_s = d_sh[STAGES-1];

endmodule

// File: rtl/audrx_framer.sv
`timescale 1ns/1ps
module audrx_framer
  import audrx_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int SLOT_BITS = 32,
  parameter int RJ_HALF   = 32,
  parameter int POS_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             lr_in,
  input  fmt_e             fmt,
  input  logic             lr_inv,
  input  logic [1:0]       rj_code,
  input  logic             tdm_pulse,
  output logic             take,
  output logic             last,
  output logic             flush,
  output logic [POS_W-1:0] kidx,
  output tag_t             tag
);

  localparam logic [POS_W-1:0] POS_MAX  = '1;
  localparam logic [POS_W-1:0] SLOT_END = POS_W'(SLOT_BITS - 1);
  localparam logic [POS_W-1:0] OFF_L0   = POS_W'(RJ_HALF - DATA_W);
  localparam logic [POS_W-1:0] OFF_L1   = POS_W'(RJ_HALF - DATA_W + 4);
  localparam logic [POS_W-1:0] OFF_L2   = POS_W'(RJ_HALF - DATA_W + 8);
  localparam logic [POS_W-1:0] HALF_LEN = POS_W'(RJ_HALF);
  localparam logic [POS_W-1:0] FULL_LEN = POS_W'(DATA_W);

  logic is_tdm, is_rj, is_i2s, delay1;
  logic lr, lr_q, lr_q2, lrd, lrd_p;
  logic [1:0] prime_q;
  logic primed, edge_any, fs_2ch, fs_tdm, bound;
  logic [POS_W-1:0] pos_q, cur_pos, off, len, k;
  logic [4:0] slot_q, cur_slot, nslots;
  logic act_q, cur_act, right;

  assign is_tdm = (fmt == FMT_TDM8) || (fmt == FMT_TDM16);
  assign is_rj  = (fmt == FMT_RJ);
  assign is_i2s = !is_tdm && !is_rj && (fmt != FMT_LJ);
  assign delay1 = is_i2s || is_tdm;
  assign nslots = (fmt == FMT_TDM16) ? 5'd16 : 5'd8;

  // One-bit-late view of the frame clock in the formats whose MSB trails the edge.
  assign lr     = lr_in ^ lr_inv;
  assign lrd    = delay1 ? lr_q  : lr;
  assign lrd_p  = delay1 ? lr_q2 : lr_q;
  assign primed = (prime_q == 2'd2);

  assign edge_any = primed && (lrd != lrd_p);
  assign fs_2ch   = edge_any && (is_i2s ? !lrd : lrd);
  assign fs_tdm   = primed && (tdm_pulse ? (!lrd_p && lrd) : (lrd_p && !lrd));
  assign bound    = is_tdm ? fs_tdm : edge_any;

  always_comb begin
    if (bound) begin
      cur_pos  = '0;
      cur_slot = '0;
      cur_act  = is_tdm ? 1'b1 : (act_q || fs_2ch);
    end else if (is_tdm && pos_q == SLOT_END) begin
      cur_pos  = '0;
      cur_slot = slot_q + 5'd1;
      cur_act  = act_q && ((slot_q + 5'd1) < nslots);
    end else begin
      cur_pos  = (pos_q == POS_MAX) ? pos_q : pos_q + 1'b1;
      cur_slot = slot_q;
      cur_act  = act_q;
    end
  end

  always_comb begin
    case (rj_code)
      2'd0:    off = OFF_L0;
      2'd1:    off = OFF_L1;
      default: off = OFF_L2;
    endcase
    if (!is_rj) off = '0;
    len = is_rj ? (HALF_LEN - off) : FULL_LEN;
  end

  assign k     = cur_pos - off;
  assign take  = stb && cur_act && (cur_pos >= off) && (k < len);
  assign last  = take && (k == len - 1'b1);
  assign flush = stb && edge_any && !is_tdm;
  assign kidx  = k;

  assign right     = is_tdm ? (cur_slot >= (nslots >> 1)) : (is_i2s ? lrd : !lrd);
  assign tag.slot  = is_tdm ? cur_slot[3:0] : {3'b000, right};
  assign tag.right = right;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_q    <= 1'b0;
      lr_q2   <= 1'b0;
      prime_q <= '0;
      pos_q   <= '0;
      slot_q  <= '0;
      act_q   <= 1'b0;
    end else if (stb) begin
      lr_q    <= lr;
      lr_q2   <= lr_q;
      prime_q <= primed ? prime_q : prime_q + 2'd1;
      pos_q   <= cur_pos;
      slot_q  <= cur_slot;
      act_q   <= cur_act;
    end
  end

endmodule

// File: rtl/audrx_assembler.sv
`timescale 1ns/1ps
module audrx_assembler
  import audrx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int POS_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              din,
  input  logic              take,
  input  logic              last,
  input  logic              flush,
  input  logic [POS_W-1:0]  kidx,
  input  tag_t              tag,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output tag_t              out_tag
);

  logic [DATA_W-1:0] w_q, w_nx;
  tag_t tag_q;
  logic pend_q;

  always_comb begin
    w_nx = w_q;
    if (take) begin
      if (kidx == '0) w_nx = '0;
      for (int i = 0; i < DATA_W; i++) begin
        if (i == DATA_W - 1 - int'(kidx)) w_nx[i] = din;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q       <= '0;
      tag_q     <= '0;
      pend_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tag   <= '0;
    end else begin
      out_valid <= 1'b0;
      if (stb) begin
        if (flush && pend_q) begin
          out_valid <= 1'b1;
          out_data  <= w_q;
          out_tag   <= tag_q;
          pend_q    <= 1'b0;
        end
        if (take) begin
          w_q <= w_nx;
          if (kidx == '0) begin
            tag_q  <= tag;
            pend_q <= 1'b1;
          end
          if (last) begin
            out_valid <= 1'b1;
            out_data  <= w_nx;
            out_tag   <= (kidx == '0) ? tag : tag_q;
            pend_q    <= 1'b0;
          end
        end
      end
    end
  end

  // R5: a bit past the MSB only lands in a word that is still open
  a_r5_cont_in_open_word: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && take && kidx != '0) |-> pend_q);

endmodule

// File: rtl/audio_serial_rx.sv
`timescale 1ns/1ps
module audio_serial_rx
  import audrx_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int SLOT_BITS   = 32,
  parameter int RJ_HALF     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_word,
  input  logic              bclk,
  input  logic              lrclk,
  input  logic              sdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [3:0]        out_slot,
  output logic              out_right
);

  localparam int SPAN  = (SLOT_BITS > 2 * RJ_HALF) ? SLOT_BITS : 2 * RJ_HALF;
  localparam int POS_W = $clog2(SPAN) + 1;

  fmt_e fmt;
  logic stb, lr_s, dat_s, take, last, flush;
  logic [POS_W-1:0] kidx;
  tag_t tag, out_tag;

  assign fmt = fmt_e'(cfg_word[2:0]);

  audrx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .bclk_inv(cfg_word[3]), .stb(stb), .lr_s(lr_s), .dat_s(dat_s)
  );

  audrx_framer #(
    .DATA_W(DATA_W), .SLOT_BITS(SLOT_BITS), .RJ_HALF(RJ_HALF), .POS_W(POS_W)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .stb(stb), .lr_in(lr_s), .fmt(fmt),
    .lr_inv(cfg_word[4]), .rj_code(cfg_word[6:5]), .tdm_pulse(cfg_word[7]),
    .take(take), .last(last), .flush(flush), .kidx(kidx), .tag(tag)
  );

  audrx_assembler #(.DATA_W(DATA_W), .POS_W(POS_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .stb(stb), .din(dat_s), .take(take), .last(last),
    .flush(flush), .kidx(kidx), .tag(tag), .out_valid(out_valid),
    .out_data(out_data), .out_tag(out_tag)
  );

  assign out_slot  = out_tag.slot;
  assign out_right = out_tag.right;

  // R10: strobe is a single cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R1: two-channel words carry slot 0/1 matching the side flag
  a_r1_two_ch_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fmt != FMT_TDM8 && fmt != FMT_TDM16) |-> (out_slot == {3'b000, out_right}));

  // R6: eight-slot frames stay in range, second half flagged
  a_r6_tdm8_half: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fmt == FMT_TDM8) |-> (!out_slot[3] && out_right == out_slot[2]));

  // R7: sixteen-slot frames flag slots 8..15
  a_r7_tdm16_half: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fmt == FMT_TDM16) |-> (out_right == out_slot[3]));

  // R3: 16-bit right-justified words leave the low byte zero
  a_r3_rj16_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fmt == FMT_RJ && cfg_word[6]) |-> (out_data[7:0] == 8'h00));

endmodule

// File: tb/audio_serial_rx_test.sv
`timescale 1ns/1ps
module audio_serial_rx_test;

  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic out_valid;
  logic [23:0] out_data;
  logic [3:0] out_slot;
  logic out_right;

  audio_serial_rx uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg), .bclk(bclk), .lrclk(lrclk),
    .sdata(sdata), .out_valid(out_valid), .out_data(out_data),
    .out_slot(out_slot), .out_right(out_right)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit cur_bi = 1'b0, cur_li = 1'b0;
  bit prev_v = 1'b0;
  bit qlr[$];
  bit qd[$];
  logic [28:0] exp_q[$];
  logic [28:0] got_q[$];

  task automatic chk(bit ok, string req, string what, logic [28:0] act, logic [28:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // R10: words never appear on consecutive cycles
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      got_q.push_back({out_right, out_slot, out_data});
      chk(!prev_v, "R10", "back-to-back strobe", 29'(prev_v), 29'd0);
    end
    prev_v = rst_n && out_valid;
  end

  task automatic do_reset(logic [7:0] c);
    rst_n = 1'b0;
    cfg = c;
    cur_bi = c[3];
    cur_li = c[4];
    bclk = cur_bi;
    lrclk = cur_li;
    sdata = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic play_bit(bit l, bit d);
    bclk = cur_bi;
    lrclk = l ^ cur_li;
    sdata = d;
    repeat (HALF) @(negedge clk);
    bclk = ~cur_bi;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic play(bit dly);
    for (int i = 0; i < qlr.size(); i++)
      play_bit(qlr[i], dly ? ((i == 0) ? 1'b0 : qd[i-1]) : qd[i]);
    qlr.delete();
    qd.delete();
    repeat (12) @(negedge clk);
  endtask

  task automatic push_bit(bit l, bit d);
    qlr.push_back(l);
    qd.push_back(d);
  endtask

  task automatic compare(string req);
    int n;
    chk(got_q.size() == exp_q.size(), req, "word count", 29'(got_q.size()), 29'(exp_q.size()));
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++)
      chk(got_q[i] === exp_q[i], req, "word {right,slot,data}", got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  function automatic logic [23:0] keep_top(logic [23:0] w, int nb);
    if (nb >= 24) return w;
    return w & (24'hFFFFFF << (24 - nb));
  endfunction

  // fmt: 0 I2S, 1 LJ, 2 RJ; h = bits per half (RJ always 32)
  task automatic run_2ch(int fmt, int h, int rjc, bit bi, bit li, int frames, string req);
    bit left_lvl;
    int len, off;
    logic [23:0] w, val;
    do_reset({1'b0, 2'(rjc), li, bi, 3'(fmt)});
    left_lvl = (fmt == 0) ? 1'b0 : 1'b1;
    len = (rjc == 0) ? 24 : (rjc == 1) ? 20 : 16;
    off = 32 - len;
    for (int i = 0; i < 20; i++) push_bit(~left_lvl, 1'($urandom));
    for (int f = 0; f < frames; f++) begin
      for (int side = 0; side < 2; side++) begin
        bit lvl;
        lvl = side ? ~left_lvl : left_lvl;
        w = 24'($urandom);
        if (fmt == 2) begin
          val = w & 24'((32'd1 << len) - 1);
          for (int j = 0; j < 32; j++)
            push_bit(lvl, (j < off) ? 1'($urandom) : val[len - 1 - (j - off)]);
          exp_q.push_back({1'(side), 3'b000, 1'(side), 24'(val << (24 - len))});
        end else begin
          for (int j = 0; j < h; j++)
            push_bit(lvl, (j < 24) ? w[23 - j] : 1'($urandom));
          exp_q.push_back({1'(side), 3'b000, 1'(side), keep_top(w, h)});
        end
      end
    end
    for (int i = 0; i < 3; i++) push_bit(left_lvl, 1'b0);
    play(fmt == 0);
    compare(req);
  endtask

  task automatic run_tdm(int n, bit pulse, bit bi, bit li, int frames, string req);
    logic [23:0] w;
    bit idle;
    do_reset({pulse, 2'b00, li, bi, (n == 16) ? 3'd4 : 3'd3});
    idle = pulse ? 1'b0 : 1'b1;
    for (int i = 0; i < 6; i++) push_bit(idle, 1'($urandom));
    for (int f = 0; f < frames; f++) begin
      for (int s = 0; s < n; s++) begin
        w = 24'($urandom);
        for (int j = 0; j < 32; j++)
          push_bit(pulse ? (s == 0 && j == 0) : (s >= n / 2), (j < 24) ? w[23 - j] : 1'($urandom));
        exp_q.push_back({1'(s >= n / 2), 4'(s), w});
      end
    end
    for (int i = 0; i < 2; i++) push_bit(idle, 1'b0);
    play(1'b1);
    compare(req);
  endtask

  initial begin
    void'($urandom(32'd7151));
    do_reset(8'h00);
    // R12: strobe low after reset and an idle line yields nothing
    chk(out_valid == 1'b0, "R12", "strobe after reset", 29'(out_valid), 29'd0);
    repeat (40) @(negedge clk);
    chk(got_q.size() == 0, "R12", "words on idle line", 29'(got_q.size()), 29'd0);

    run_2ch(0, 32, 0, 0, 0, 3, "R1 R4 R11");
    run_2ch(0, 16, 0, 0, 0, 2, "R5 R1");
    run_2ch(1, 24, 0, 0, 0, 3, "R2 R11");
    run_2ch(1, 20, 0, 0, 0, 2, "R5 R2");
    run_2ch(1, 31, 0, 0, 0, 2, "R4");
    run_2ch(2, 32, 0, 0, 0, 2, "R3 len24");
    run_2ch(2, 32, 1, 0, 0, 2, "R3 len20");
    run_2ch(2, 32, 2, 0, 0, 2, "R3 len16");
    run_tdm(8, 0, 0, 0, 2, "R6");
    run_tdm(16, 0, 0, 0, 2, "R7");
    run_tdm(8, 1, 0, 0, 2, "R8");
    run_tdm(16, 1, 1, 1, 1, "R8 R9");
    run_2ch(0, 32, 0, 1, 1, 2, "R9 i2s");
    run_2ch(2, 32, 1, 1, 0, 2, "R9 R3");
    run_tdm(8, 0, 0, 1, 1, "R9 R6");

    for (int r = 0; r < 6; r++) begin
      int fm, hh;
      fm = int'($urandom % 2);
      hh = 16 + int'($urandom % 17);
      run_2ch(fm, hh, 0, 1'($urandom), 1'($urandom), 2, "R1 R2 R5 R9 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule